// File: doc/BRIEF.md
# Dendritic Compartment Join Tree

This block reduces the input currents of one neuron's dendritic compartments to a single value for the soma. Every compartment carries its own signed 24-bit input, a two-bit code selecting how children are merged into it, and the index of its parent. Compartment 0 is the root. When a set of inputs is presented with a one-cycle strobe, the block captures it. It then folds each child into its parent, one link per clock and highest index first, using the parent's merge operation. It finishes by presenting the root value together with a one-cycle completion pulse.

A merge can be a saturating sum, a signed pick of the operand with the larger magnitude, a logical OR reduced to 0 or 1, or a pass of the child alone. With these, a dendrite can do nonlinear work of its own before the soma sees the result. One example is to keep only the strongest of several branches.

Top module: `dendrite_join_tree`

## Requirements
- R1: After reset, `done` is 0 and `root_out` is 0.
- R2: Merge code 00 adds the parent's current value and the child's value, saturating to 8388607 and -8388608.
- R3: Merge code 01 keeps whichever operand has the larger magnitude, sign included; when the magnitudes are equal it keeps the parent's value.
- R4: Merge code 10 yields 1 if either operand is nonzero and 0 if both are zero.
- R5: Merge code 11 replaces the parent's value with the child's value. When several children feed one such parent, the child with the lowest index is merged last, so its value remains.
- R6: Children are merged one at a time from index NUM_COMP-1 down to 1. Each child is merged into the value its parent has accumulated so far, using the merge code of that parent. A child's own merge code only affects its own children.
- R7: `done` is high for exactly one cycle, NUM_COMP rising edges after the edge that accepts `in_valid`. `root_out` keeps that result until the next completion.
- R8: A strobe on `in_valid` during an evaluation is ignored and does not change its result.
- R9: A compartment i ≥ 1 whose parent index is not less than i is detached, and its value reaches no other compartment. The parent field of compartment 0 has no effect.
- R10: Compartment i uses bits [24i+23:24i] of `comp_in`, bits [2i+1:2i] of `join_op` and bits [2i+1:2i] of `parent_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that captures a new input set when the block is idle |
| comp_in | input | NUM_COMP*DATA_W | Signed input of each compartment |
| join_op | input | NUM_COMP*2 | Merge code of each compartment |
| parent_sel | input | NUM_COMP*IDX_W | Parent index of each compartment |
| root_out | output | DATA_W | Signed value of the root after merging |
| done | output | 1 | One-cycle pulse that marks a new `root_out` |

## Verification
The hardest case is a merge whose outcome depends on the order of the links. Examples are a pass-through parent with several children, or a chain in which an inner node's nonlinear merge changes what its grandparent receives. Such cases appear only for particular combinations of topology and codes. The stimulus sweeps all 64 settings of the three parent fields against a strided range of the 256 code combinations. Input values are drawn from a set that rotates through the saturation limits, equal and opposite magnitudes, and zero. Directed runs then cover the tie, saturation, detached-link and mid-evaluation-strobe cases.

// File: rtl/dtree_pkg.sv
package dtree_pkg;
  typedef enum logic [1:0] {
    JOIN_ADD    = 2'b00,
    JOIN_ABSMAX = 2'b01,
    JOIN_OR     = 2'b10,
    JOIN_PASS   = 2'b11
  } join_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'b00,
    SEQ_RUN  = 2'b01,
    SEQ_FIN  = 2'b10
  } seq_e;
endpackage

// File: rtl/dtree_join_alu.sv
module dtree_join_alu
  import dtree_pkg::*;
#(
  parameter int W = 24
) (
  input  join_e                op,
  input  logic signed [W-1:0]  a_par,
  input  logic signed [W-1:0]  a_chd,
  output logic signed [W-1:0]  res
);
  localparam logic signed [W:0] MAXV = {2'b00, {(W-1){1'b1}}};
  localparam logic signed [W:0] MINV = {2'b11, {(W-1){1'b0}}};

  logic signed [W:0] ext_p, ext_c, sum;
  logic        [W:0] mag_p, mag_c;

  assign ext_p = {a_par[W-1], a_par};
  assign ext_c = {a_chd[W-1], a_chd};
  assign sum   = ext_p + ext_c;
  assign mag_p = ext_p[W] ? (~ext_p + 1'b1) : ext_p;
  assign mag_c = ext_c[W] ? (~ext_c + 1'b1) : ext_c;

  always_comb begin
    res = a_chd;
    case (op)
      JOIN_ADD: begin
        if (sum > MAXV)      res = MAXV[W-1:0];
        else if (sum < MINV) res = MINV[W-1:0];
        else                 res = sum[W-1:0];
      end
      JOIN_ABSMAX: res = (mag_c > mag_p) ? a_chd : a_par;
      JOIN_OR:     res = ((|a_par) || (|a_chd)) ? {{(W-1){1'b0}}, 1'b1} : '0;
      JOIN_PASS:   res = a_chd;
      default:     res = a_chd;
    endcase
  end
endmodule

// File: rtl/dtree_seq.sv
module dtree_seq
  import dtree_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          step,
  output logic          finish,
  output logic [IW-1:0] child
);
  seq_e          st;
  logic [IW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= SEQ_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        SEQ_IDLE: if (start) begin
          st  <= SEQ_RUN;
          cnt <= IW'(N-1);
        end
        SEQ_RUN: begin
          if (cnt == IW'(1)) st <= SEQ_FIN;
          else               cnt <= cnt - 1'b1;
        end
        SEQ_FIN: st <= SEQ_IDLE;
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  assign busy   = (st != SEQ_IDLE);
  assign step   = (st == SEQ_RUN);
  assign finish = (st == SEQ_FIN);
  assign child  = cnt;
endmodule

// File: rtl/dtree_store.sv
module dtree_store
  import dtree_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 24,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                load,
  input  logic [N*W-1:0]      load_val,
  input  logic [N*2-1:0]      load_op,
  input  logic [N*IW-1:0]     load_par,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_addr,
  input  logic signed [W-1:0] wr_data,
  input  logic [IW-1:0]       rd_child,
  output logic signed [W-1:0] child_val,
  output logic [IW-1:0]       child_par,
  output logic signed [W-1:0] par_val,
  output join_e               par_op,
  output logic signed [W-1:0] root_val
);
  logic signed [W-1:0] acc_mem [N];
  join_e               op_mem  [N];
  logic [IW-1:0]       par_mem [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (load) begin
        acc_mem[g] <= load_val[g*W +: W];
        op_mem[g]  <= join_e'(load_op[g*2 +: 2]);
        par_mem[g] <= load_par[g*IW +: IW];
      end else if (wr_en && wr_addr == IW'(g)) begin
        acc_mem[g] <= wr_data;
      end
    end
  end

  assign child_val = acc_mem[rd_child];
  assign child_par = par_mem[rd_child];
  assign par_val   = acc_mem[child_par];
  assign par_op    = op_mem[child_par];
  assign root_val  = acc_mem[0];
endmodule

// File: rtl/dendrite_join_tree.sv
module dendrite_join_tree
  import dtree_pkg::*;
#(
  parameter int NUM_COMP = 4,
  parameter int DATA_W   = 24,
  localparam int IDX_W   = (NUM_COMP > 1) ? $clog2(NUM_COMP) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [NUM_COMP*DATA_W-1:0] comp_in,
  input  logic [NUM_COMP*2-1:0]     join_op,
  input  logic [NUM_COMP*IDX_W-1:0] parent_sel,
  output logic [DATA_W-1:0]         root_out,
  output logic                      done
);
  logic                     busy, step, finish, accept, link_ok, wr_en;
  logic [IDX_W-1:0]         child_idx, child_par;
  logic signed [DATA_W-1:0] child_val, par_val, merge_val, root_val;
  join_e                    par_op;
  logic [DATA_W-1:0]        root_q;
  logic                     done_q;

  assign accept  = in_valid && !busy;
  assign link_ok = (child_par < child_idx);
  assign wr_en   = step && link_ok;

  dtree_seq #(.N(NUM_COMP)) u_seq (
    .clk(clk), .rst(rst), .start(accept),
    .busy(busy), .step(step), .finish(finish), .child(child_idx)
  );

  dtree_store #(.N(NUM_COMP), .W(DATA_W)) u_store (
    .clk(clk), .load(accept),
    .load_val(comp_in), .load_op(join_op), .load_par(parent_sel),
    .wr_en(wr_en), .wr_addr(child_par), .wr_data(merge_val),
    .rd_child(child_idx), .child_val(child_val), .child_par(child_par),
    .par_val(par_val), .par_op(par_op), .root_val(root_val)
  );

  dtree_join_alu #(.W(DATA_W)) u_alu (
    .op(par_op), .a_par(par_val), .a_chd(child_val), .res(merge_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      root_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) root_q <= root_val;
    end
  end

  assign root_out = root_q;
  assign done     = done_q;
endmodule

// File: rtl/dendrite_join_tree_chk.sv
module dendrite_join_tree_chk
  import dtree_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 24
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                busy,
  input logic                done,
  input logic                step,
  input join_e               alu_op,
  input logic signed [W-1:0] alu_p,
  input logic signed [W-1:0] alu_c,
  input logic signed [W-1:0] alu_res
);
  logic [15:0] lat;

  always_ff @(posedge clk) begin
    if (rst)                   lat <= '0;
    else if (in_valid && !busy) lat <= 16'd1;
    else if (done)             lat <= '0;
    else if (lat != 16'd0 && lat != 16'hFFFF) lat <= lat + 16'd1;
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> lat == 16'(N + 1));

  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_amax_pick_r3: assert property (@(posedge clk) disable iff (rst)
    (step && alu_op == JOIN_ABSMAX) |-> (alu_res == alu_p || alu_res == alu_c));

  p_or_bool_r4: assert property (@(posedge clk) disable iff (rst)
    (step && alu_op == JOIN_OR) |-> (alu_res == '0 || alu_res == W'(1)));

  p_or_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (step && alu_op == JOIN_OR && alu_p == '0 && alu_c == '0) |-> alu_res == '0);

  p_pass_child_r5: assert property (@(posedge clk) disable iff (rst)
    (step && alu_op == JOIN_PASS) |-> alu_res == alu_c);
endmodule

bind dendrite_join_tree dendrite_join_tree_chk #(.N(NUM_COMP), .W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .busy(busy), .done(done),
  .step(step), .alu_op(par_op), .alu_p(par_val), .alu_c(child_val),
  .alu_res(merge_val)
);

// File: tb/dendrite_join_tree_test.sv
module dendrite_join_tree_test;
  localparam int N = 4;
  localparam int W = 24;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [N*W-1:0] comp_in = '0;
  logic [N*2-1:0] join_op = '0;
  logic [N*2-1:0] parent_sel = '0;
  logic [W-1:0]   root_out;
  logic           done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dendrite_join_tree #(.NUM_COMP(N), .DATA_W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .comp_in(comp_in),
    .join_op(join_op), .parent_sel(parent_sel), .root_out(root_out), .done(done)
  );

  function automatic longint tv(int k);
    case (k % 8)
      0: return 0;
      1: return 1;
      2: return -1;
      3: return 8388607;
      4: return -8388608;
      5: return 100;
      6: return -100;
      default: return -8388607;
    endcase
  endfunction

  function automatic longint absl(longint x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic longint mrg(int op, longint a, longint c);
    longint s;
    case (op)
      0: begin
        s = a + c;
        if (s > 8388607) s = 8388607;
        if (s < -8388608) s = -8388608;
        return s;
      end
      1: return (absl(c) > absl(a)) ? c : a;
      2: return (a != 0 || c != 0) ? 1 : 0;
      default: return c;
    endcase
  endfunction

  function automatic longint model(logic [N*W-1:0] v, logic [N*2-1:0] o, logic [N*2-1:0] p);
    longint a [N];
    for (int i = 0; i < N; i++) a[i] = longint'($signed(v[i*W +: W]));
    for (int c = N-1; c >= 1; c--) begin
      int pc;
      pc = int'(p[c*2 +: 2]);
      if (pc < c) a[pc] = mrg(int'(o[pc*2 +: 2]), a[pc], a[c]);
    end
    return a[0];
  endfunction

  function automatic logic [N*W-1:0] pack4(longint v0, longint v1, longint v2, longint v3);
    logic [N*W-1:0] r;
    r[0*W +: W] = W'(v0);
    r[1*W +: W] = W'(v1);
    r[2*W +: W] = W'(v2);
    r[3*W +: W] = W'(v3);
    return r;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [N*W-1:0] v, input logic [N*2-1:0] o,
                     input logic [N*2-1:0] p, output int lat, output longint res);
    comp_in    = v;
    join_op    = o;
    parent_sel = p;
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    res = longint'($signed(root_out));
  endtask

  task automatic finish_up;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    int lat;
    longint res, exp;
    logic [N*W-1:0] v;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 done", longint'(done), 0);
    check("R1 root", longint'($signed(root_out)), 0);

    // R2 saturation at positive and negative limits (root ADD, child 1 into 0, others detached)
    run(pack4(8388607, 1, 0, 0), 8'b00_00_00_00, 8'b11_10_00_00, lat, res);
    check("R2 pos sat", res, 8388607);
    run(pack4(-8388608, -5, 0, 0), 8'b00_00_00_00, 8'b11_10_00_00, lat, res);
    check("R2 neg sat", res, -8388608);
    run(pack4(300, -1000, 0, 0), 8'b00_00_00_00, 8'b11_10_00_00, lat, res);
    check("R2 plain sum", res, -700);

    // R3 tie keeps parent, larger magnitude wins with sign
    run(pack4(100, -100, 0, 0), 8'b00_00_00_01, 8'b11_10_00_00, lat, res);
    check("R3 tie", res, 100);
    run(pack4(100, -101, 0, 0), 8'b00_00_00_01, 8'b11_10_00_00, lat, res);
    check("R3 larger", res, -101);

    // R4 OR of zeros and of a nonzero
    run(pack4(0, 0, 0, 0), 8'b00_00_00_10, 8'b11_10_00_00, lat, res);
    check("R4 zeros", res, 0);
    run(pack4(0, -7, 0, 0), 8'b00_00_00_10, 8'b11_10_00_00, lat, res);
    check("R4 nonzero", res, 1);

    // R5 several children on a PASS root: lowest index remains
    run(pack4(5, 10, 20, 30), 8'b00_00_00_11, 8'b00_00_00_00, lat, res);
    check("R5 pass order", res, 10);

    // R6 chain 3->2->1->0: ABSMAX at 2, ADD at 1, ADD at 0
    run(pack4(1, 2, -50, 70), 8'b10_01_00_00, 8'b10_01_00_11, lat, res);
    check("R6 chain", res, 73);

    // R9 detached self and forward links; root parent field ignored
    run(pack4(1, 99, 0, 0), 8'b00_00_00_00, 8'b11_10_01_11, lat, res);
    check("R9 detach", res, 1);
    run(pack4(1, 5, 0, 0), 8'b00_00_00_00, 8'b11_11_00_10, lat, res);
    check("R9 forward", res, 6);

    // R10 only compartment 2 contributes, through its own field slots
    run(pack4(4, 0, 11, 0), 8'b00_00_00_00, 8'b11_00_01_00, lat, res);
    check("R10 field", res, 15);

    // R7 latency, single-cycle pulse and hold
    run(pack4(2, 3, 0, 0), 8'b00_00_00_00, 8'b11_10_00_00, lat, res);
    check("R7 latency", longint'(lat), N);
    @(negedge clk);
    check("R7 pulse", longint'(done), 0);
    repeat (3) @(negedge clk);
    check("R7 hold", longint'($signed(root_out)), 5);

    // R8 strobe during evaluation is ignored
    comp_in = pack4(1, 2, 3, 4); join_op = 8'b00_00_00_00; parent_sel = 8'b00_00_00_00;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    comp_in = pack4(1000, 2000, 3000, 4000); join_op = 8'b11_11_11_11;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check("R8 ignore", longint'($signed(root_out)), 10);

    // R6 sweep over all parent settings and strided merge codes
    for (int p = 0; p < 64; p++) begin
      for (int o = 0; o < 256; o += 3) begin
        logic [N*2-1:0] pv, ov;
        pv = {2'(p >> 4), 2'(p >> 2), 2'(p), 2'b00};
        ov = 8'(o);
        v = pack4(tv(p + o), tv(p * 3 + o + 5), tv(p + 2 * o + 2), tv(p * 5 + o + 7));
        exp = model(v, ov, pv);
        run(v, ov, pv, lat, res);
        check("R6 sweep", res, exp);
      end
    end

    finish_up();
  end
endmodule